// File: doc/BRIEF.md
# Priority Interrupt Claim/Complete Controller

This block gathers level-sensitive interrupt request lines from a set of devices and routes them to several harts. Each line carries a source number from 1 upward. Each source has a small programmable priority. Each hart has its own threshold and its own enable bitmap over the sources. For every hart the block drives an external-interrupt output. That output is high while an enabled pending source has a priority strictly greater than the hart's threshold.

Software takes an interrupt by reading its hart's claim register. The read returns the number of the best enabled pending source and takes ownership of it in the same step. Once the device has been serviced, software writes that number back to the same register. The source then becomes free again. While a source is claimed it cannot pend again, even if its line stays high. All configuration travels over a simple 32-bit memory-mapped bus. A read returns its data in the cycle after the request.

Address map, in bytes. Bits [9:7] select a region and bits [6:2] select an index:
- Priority of source s: 0x000 + 4s.
- Pending bitmap (read-only, bit s = source s): 0x080.
- Threshold of hart h: 0x100 + 4h.
- Claim/complete of hart h: 0x180 + 4h.
- Enable bitmap of hart h (bit s = source s): 0x200 + 4h.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After synchronous reset, every priority, threshold, enable bit, pending bit and claim is zero, every interrupt output is low, and reads of the priority, pending and claim registers return 0.
- R2: A source whose line is high at a clock edge, and which is neither pending nor claimed, shows as pending (bit s of the pending bitmap at 0x080) from that edge on.
- R3: A hart's interrupt output is high exactly when some source that is pending and enabled for that hart has a priority strictly greater than that hart's threshold. A priority equal to the threshold does not raise it.
- R4: A claim read returns the pending source, enabled for that hart, with the highest priority, regardless of the threshold. Ties go to the lowest source number. A source of priority 0 is never returned.
- R5: A claim read returns 0 when no source is eligible. Such a read changes no state.
- R6: A claim clears the source's pending bit. The source cannot pend again before its completion, even while its line stays high.
- R7: Writing a claimed source number to any hart's claim register completes that source. If its line is still high, the source pends again on the following edge. If the line is low, it stays idle.
- R8: A completion write naming a source that is not claimed is ignored. Its pending state and the result of the next claim are unchanged.
- R9: A source claimed by one hart is no longer offered to any hart from the next cycle on.
- R10: Priority and threshold registers keep only their 3 low bits. Enable bit 0 always reads 0. Each configuration register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_SRC | Level request lines; bit s is source s (index runs NUM_SRC down to 1) |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read request |
| eip_o | output | NUM_HART | Per-hart external-interrupt output |

## Verification
A bus request that is held during one cycle takes effect at the next rising edge. The read data appears just after that edge, so the scoreboard monitor compares it 2 ns after the edge of the request. A request line raised between edges becomes pending at the next edge. The interrupt outputs follow combinationally, so the bench waits two edges after changing a line before it checks the outputs. A completion frees the source at the write's edge, and a line that is still high pends it again one edge later. The bench therefore leaves at least one idle cycle between a completion and the read of the pending bitmap.

// File: rtl/irq_cc_pkg.sv
package irq_cc_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 10;
    localparam int IDX_W  = 5;

    typedef enum logic [2:0] {
        RGN_PRIO  = 3'd0,
        RGN_PEND  = 3'd1,
        RGN_THR   = 3'd2,
        RGN_CLAIM = 3'd3,
        RGN_EN    = 3'd4,
        RGN_NONE5 = 3'd5,
        RGN_NONE6 = 3'd6,
        RGN_NONE7 = 3'd7
    } region_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        region_e          rgn;
        logic [IDX_W-1:0] idx;
        logic [BUS_W-1:0] data;
    } bus_op_t;

    function automatic bus_op_t decode_bus(input logic req, input logic we,
                                           input logic [ADDR_W-1:0] addr,
                                           input logic [BUS_W-1:0] wdata);
        bus_op_t op;
        op.rd   = req && !we;
        op.wr   = req && we;
        op.rgn  = region_e'(addr[9:7]);
        op.idx  = addr[6:2];
        op.data = wdata;
        return op;
    endfunction

    function automatic int id_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/irq_cc_gateway.sv
module irq_cc_gateway (
    input  logic clk,
    input  logic rst,
    input  logic irq_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pending_o,
    output logic claimed_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_o <= 1'b0;
            claimed_o <= 1'b0;
        end else if (claim_i && pending_o) begin
            pending_o <= 1'b0;
            claimed_o <= 1'b1;
        end else if (done_i && claimed_o) begin
            claimed_o <= 1'b0;
        end else if (!claimed_o && !pending_o && irq_i) begin
            pending_o <= 1'b1;
        end
    end

    // R6
    gw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pending_o && claimed_o));

    // R6
    gw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (claimed_o && !done_i) |=> (claimed_o && !pending_o));

    // R2
    gw_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (!pending_o && !claimed_o && irq_i) |=> pending_o);

    // R8
    gw_stray_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && !claimed_o && !pending_o && !irq_i) |=> (!pending_o && !claimed_o));

endmodule

// File: rtl/irq_cc_arbiter.sv
module irq_cc_arbiter #(
    parameter int NUM_SRC = 15,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 4
) (
    input  logic [NUM_SRC:0]             cand_i,
    input  logic [NUM_SRC:0][PRIO_W-1:0] prio_i,
    output logic [ID_W-1:0]              best_id_o,
    output logic [PRIO_W-1:0]            best_prio_o
);

    always_comb begin
        best_id_o   = '0;
        best_prio_o = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (cand_i[i] && (prio_i[i] > best_prio_o)) begin
                best_id_o   = ID_W'(i);
                best_prio_o = prio_i[i];
            end
        end
    end

    always_comb begin
        if (best_id_o != '0) begin
            // R4
            arb_pick_chk: assert (cand_i[best_id_o] && (prio_i[best_id_o] == best_prio_o)
                                  && (best_prio_o != '0));
        end
    end

endmodule

// File: rtl/irq_cc_regs.sv
module irq_cc_regs
    import irq_cc_pkg::*;
#(
    parameter int NUM_SRC  = 15,
    parameter int NUM_HART = 2,
    parameter int PRIO_W   = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  bus_op_t                           op_i,
    output logic [NUM_SRC:0][PRIO_W-1:0]      prio_o,
    output logic [NUM_HART-1:0][PRIO_W-1:0]   thr_o,
    output logic [NUM_HART-1:0][NUM_SRC:0]    en_o,
    output logic [BUS_W-1:0]                  cfg_rdata_o
);

    assign prio_o[0] = '0;

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_prio
        logic [PRIO_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else if (op_i.wr && op_i.rgn == RGN_PRIO && op_i.idx == IDX_W'(s))
                q <= op_i.data[PRIO_W-1:0];
        end
        assign prio_o[s] = q;

        // R10
        reg_prio_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (op_i.wr && op_i.rgn == RGN_PRIO && op_i.idx == IDX_W'(s))
            |=> (prio_o[s] == $past(op_i.data[PRIO_W-1:0])));
    end

    for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
        logic [PRIO_W-1:0] thr_q;
        logic [NUM_SRC:0]  en_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q <= '0;
                en_q  <= '0;
            end else if (op_i.wr && op_i.idx == IDX_W'(h)) begin
                if (op_i.rgn == RGN_THR) thr_q <= op_i.data[PRIO_W-1:0];
                if (op_i.rgn == RGN_EN)  en_q  <= {op_i.data[NUM_SRC:1], 1'b0};
            end
        end
        assign thr_o[h] = thr_q;
        assign en_o[h]  = en_q;
    end

    always_comb begin
        cfg_rdata_o = '0;
        unique case (op_i.rgn)
            RGN_PRIO: begin
                for (int s = 1; s <= NUM_SRC; s++)
                    if (op_i.idx == IDX_W'(s)) cfg_rdata_o = BUS_W'(prio_o[s]);
            end
            RGN_THR: begin
                for (int h = 0; h < NUM_HART; h++)
                    if (op_i.idx == IDX_W'(h)) cfg_rdata_o = BUS_W'(thr_o[h]);
            end
            RGN_EN: begin
                for (int h = 0; h < NUM_HART; h++)
                    if (op_i.idx == IDX_W'(h)) cfg_rdata_o = BUS_W'(en_o[h]);
            end
            default: cfg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
    import irq_cc_pkg::*;
#(
    parameter int NUM_SRC  = 15,
    parameter int NUM_HART = 2,
    parameter int PRIO_W   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC:1]    irq_i,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic [NUM_HART-1:0] eip_o
);

    localparam int ID_W = id_width(NUM_SRC + 1);
    localparam logic [IDX_W:0] HART_LIM = (IDX_W+1)'(NUM_HART);

    bus_op_t op;
    assign op = decode_bus(bus_req, bus_we, bus_addr, bus_wdata);

    logic [NUM_SRC:0][PRIO_W-1:0]    prio;
    logic [NUM_HART-1:0][PRIO_W-1:0] thr;
    logic [NUM_HART-1:0][NUM_SRC:0]  en;
    logic [BUS_W-1:0]                cfg_rdata;

    irq_cc_regs #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst(rst), .op_i(op),
        .prio_o(prio), .thr_o(thr), .en_o(en), .cfg_rdata_o(cfg_rdata)
    );

    logic [NUM_SRC:0] pending;
    logic [NUM_SRC:0] claimed;
    assign pending[0] = 1'b0;
    assign claimed[0] = 1'b0;

    logic [NUM_HART-1:0][ID_W-1:0]   best_id;
    logic [NUM_HART-1:0][PRIO_W-1:0] best_prio;

    for (genvar h = 0; h < NUM_HART; h++) begin : g_arb
        irq_cc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .cand_i(pending & en[h]), .prio_i(prio),
            .best_id_o(best_id[h]), .best_prio_o(best_prio[h])
        );
        assign eip_o[h] = best_prio[h] > thr[h];
    end

    logic            hart_ok;
    logic            claim_hit;
    logic            done_hit;
    logic [ID_W-1:0] claim_id;

    assign hart_ok   = {1'b0, op.idx} < HART_LIM;
    assign claim_hit = op.rd && op.rgn == RGN_CLAIM && hart_ok;
    assign done_hit  = op.wr && op.rgn == RGN_CLAIM && hart_ok;

    always_comb begin
        claim_id = '0;
        for (int h = 0; h < NUM_HART; h++)
            if (op.idx == IDX_W'(h)) claim_id = best_id[h];
    end

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
        irq_cc_gateway u_gw (
            .clk(clk), .rst(rst), .irq_i(irq_i[s]),
            .claim_i(claim_hit && claim_id == ID_W'(s)),
            .done_i(done_hit && op.data == BUS_W'(s)),
            .pending_o(pending[s]), .claimed_o(claimed[s])
        );
    end

    logic [BUS_W-1:0] rdata_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (op.rd) begin
            unique case (op.rgn)
                RGN_CLAIM: rdata_q <= claim_hit ? BUS_W'(claim_id) : '0;
                RGN_PEND:  rdata_q <= BUS_W'(pending);
                default:   rdata_q <= cfg_rdata;
            endcase
        end
    end
    assign bus_rdata = rdata_q;

    for (genvar h = 0; h < NUM_HART; h++) begin : g_chk
        // R9
        top_reclaim_chk: assert property (@(posedge clk) disable iff (rst)
            (claim_hit && claim_id != '0) |=> (best_id[h] != $past(claim_id)));

        // R3
        top_eip_src_chk: assert property (@(posedge clk) disable iff (rst)
            eip_o[h] |-> (best_id[h] != '0));
    end

    // R5
    top_empty_claim_chk: assert property (@(posedge clk) disable iff (rst)
        (claim_hit && claim_id == '0) |=> ($stable(pending) && $stable(claimed)));

endmodule

// File: tb/irq_claim_ctrl_tb.sv
`timescale 1ns/1ps
module irq_claim_ctrl_tb;

    localparam int NS = 15;
    localparam int NH = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS:1]   irq = '0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NH-1:0] eip;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    irq_claim_ctrl #(.NUM_SRC(NS), .NUM_HART(NH), .PRIO_W(3)) u_dut (
        .clk(clk), .rst(rst), .irq_i(irq), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eip_o(eip)
    );

    function automatic logic [9:0] a_prio(int s);  return 10'(s * 4);          endfunction
    function automatic logic [9:0] a_thr(int h);   return 10'(12'h100 + h * 4); endfunction
    function automatic logic [9:0] a_claim(int h); return 10'(12'h180 + h * 4); endfunction
    function automatic logic [9:0] a_en(int h);    return 10'(12'h200 + h * 4); endfunction
    localparam logic [9:0] A_PEND = 10'h080;

    // monitor: pop one expected item per read, 2 ns after the executing edge
    always begin
        logic was_rd;
        @(posedge clk);
        was_rd = bus_req && !bus_we;
        #2;
        if (was_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual=0x%08h expected=0x%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic chk_eip(input logic [NH-1:0] e, input string t);
        @(negedge clk);
        checks++;
        if (eip !== e) begin
            errors++;
            $display("FAIL %s: eip actual=%b expected=%b", t, eip, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_eip(2'b00, "R1 eip after reset");
        bus_read(a_prio(3), 32'h0, "R1 prio reset");
        bus_read(A_PEND, 32'h0, "R1 pending reset");
        bus_read(a_claim(0), 32'h0, "R1 claim reset");

        // R10 masking and readback
        bus_write(a_prio(3), 32'hF);
        bus_read(a_prio(3), 32'h7, "R10 prio masked");
        bus_write(a_thr(1), 32'h2);
        bus_read(a_thr(1), 32'h2, "R10 threshold readback");
        bus_write(a_en(0), 32'hFFFF);
        bus_read(a_en(0), 32'hFFFE, "R10 enable bit0 zero");
        bus_write(a_en(1), 32'h60);
        bus_write(a_prio(5), 32'h4);
        bus_write(a_prio(6), 32'h4);

        // R2 / R4 / R5 priority-0 source
        irq[2] = 1'b1;
        idle(2);
        bus_read(A_PEND, 32'h4, "R2 pending bit set");
        chk_eip(2'b00, "R3 prio zero no eip");
        bus_read(a_claim(0), 32'h0, "R5 claim with none eligible");
        bus_read(A_PEND, 32'h4, "R5 empty claim no change");

        // R3 threshold compare
        irq[5] = 1'b1; irq[6] = 1'b1;
        idle(2);
        chk_eip(2'b11, "R3 both harts above threshold");
        bus_write(a_thr(1), 32'h4);
        chk_eip(2'b01, "R3 equal threshold blocks");

        // R4 tie to lowest id, threshold ignored; R9 removal
        bus_read(a_claim(1), 32'd5, "R4 tie lowest id");
        bus_read(a_claim(0), 32'd6, "R9 claimed source withheld");
        bus_read(A_PEND, 32'h4, "R6 claimed not repending");
        chk_eip(2'b00, "R6 eip after claims");

        // R4 highest priority
        irq[3] = 1'b1;
        idle(2);
        chk_eip(2'b01, "R3 hart1 not enabled");
        bus_read(a_claim(0), 32'd3, "R4 highest priority");
        chk_eip(2'b00, "R6 eip after claim of 3");

        // R7 completion with line still high
        bus_write(a_claim(1), 32'd5);
        idle(1);
        bus_read(A_PEND, 32'h24, "R7 repend after completion");
        chk_eip(2'b01, "R3 eip after repend");

        // R8 completion of unclaimed source ignored
        bus_write(a_claim(0), 32'd5);
        idle(1);
        bus_read(A_PEND, 32'h24, "R8 stray completion ignored");
        bus_read(a_claim(1), 32'd5, "R8 source still claimable");
        bus_read(A_PEND, 32'h4, "R6 claim clears pending");

        // R7 completion with line low
        irq[6] = 1'b0;
        bus_write(a_claim(0), 32'd6);
        idle(1);
        bus_read(A_PEND, 32'h4, "R7 line low stays idle");
        bus_read(a_claim(0), 32'h0, "R5 nothing left eligible");

        idle(3);
        wait (exp_q.size() == 0);
        report();
    end

endmodule